// File: doc/BRIEF.md
# UART FIFO Trigger Level Selector

This block sits beside the receive and transmit FIFOs of a serial port, each 64 entries deep. It decides how full the receive FIFO must be before the receiver asks to be serviced, and how empty the transmit FIFO must be before the transmitter asks for more data. It compares the live fill counts against those thresholds and raises two request flags for the interrupt logic downstream.

A two-bit source-select field chooses where the thresholds come from. One setting uses a fixed, non-uniform table with separate two-bit codes for receive and transmit. Another takes both thresholds from programmable byte registers, after sanitising them. The remaining settings, and a low FIFO enable, fall back to single-character holding-register behaviour. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_trig_sel`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `rx_req`=0, `tx_req`=0, `rx_thr`=1 and `tx_thr`=0.
- R2: With `fifo_en`=1 and `tbl_sel`=2'b10, `rx_thr` is set from `rx_code`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 56 and 2'b11 gives 60.
- R3: With `fifo_en`=1 and `tbl_sel`=2'b10, `tx_thr` is set from `tx_code`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 56.
- R4: With `fifo_en`=1 and `tbl_sel`=2'b11, `rx_code` and `tx_code` have no effect. A programmable value from 1 to 64 in `rx_prog` or `tx_prog` becomes `rx_thr` or `tx_thr` unchanged.
- R5: In the programmable setting, a register value of 0 gives a threshold of 1, and a value above 64 gives 64.
- R6: `rx_req` is 1 exactly when the receive count sampled at the previous edge was at or above the receive threshold in effect for that sample. It drops on the first cycle after the count falls below that threshold.
- R7: `tx_req` is 1 exactly when the transmit count sampled at the previous edge was at or below the transmit threshold in effect for that sample.
- R8: With `fifo_en`=1 and `tbl_sel` equal to 2'b00 or 2'b01, `rx_thr`=1 and `tx_thr`=0. The receive request then fires on any data, and the transmit request fires only when the transmit FIFO is empty.
- R9: With `fifo_en`=0, the thresholds are `rx_thr`=1 and `tx_thr`=0 whatever `tbl_sel`, the codes and the programmable registers hold.
- R10: Every output reflects the inputs sampled at the previous rising edge of `clk`, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable; low selects single-character behaviour |
| tbl_sel | input | 2 | Threshold source select |
| rx_code | input | 2 | Fixed-table receive threshold code |
| tx_code | input | 2 | Fixed-table transmit threshold code |
| rx_prog | input | 8 | Programmable receive threshold |
| tx_prog | input | 8 | Programmable transmit threshold |
| rx_cnt | input | 7 | Receive FIFO fill count, 0 to 64 |
| tx_cnt | input | 7 | Transmit FIFO fill count, 0 to 64 |
| rx_req | output | 1 | Receive-ready request |
| tx_req | output | 1 | Transmit-ready request |
| rx_thr | output | 7 | Receive threshold in effect |
| tx_thr | output | 7 | Transmit threshold in effect |

## Verification
The bench walks every combination of FIFO enable, source select, receive code and transmit code. Each combination is tried with programmable values of 0, 1, 5, 63, 64, 65 and 200, which separate the pass-through case from the clamping at both ends. For each setting the receive count ramps through every value from 0 to 64, and the transmit count runs through a scrambled order of the same range. This puts each threshold's exact edge, the values one count either side of it, and the empty and full extremes in front of both comparators. The legacy and disabled settings differ from the fixed table only in the thresholds they select, so any mix-up between the source settings shows up as a threshold or request mismatch.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;

    localparam int FIFO_DEPTH = 64;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int PROG_W     = 8;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PROG_W-1:0] prog_t;

    typedef enum logic [1:0] {
        SRC_SINGLE = 2'd0,
        SRC_FIXED  = 2'd1,
        SRC_PROG   = 2'd2
    } thr_src_e;

    typedef struct packed {
        cnt_t rx;
        cnt_t tx;
    } thr_pair_t;

    function automatic thr_src_e decode_src(input logic en, input logic [1:0] sel);
        if (!en)              return SRC_SINGLE;
        else if (sel == 2'b10) return SRC_FIXED;
        else if (sel == 2'b11) return SRC_PROG;
        else                  return SRC_SINGLE;
    endfunction

    function automatic cnt_t fixed_rx_level(input logic [1:0] code);
        case (code)
            2'b00:   return cnt_t'(8);
            2'b01:   return cnt_t'(16);
            2'b10:   return cnt_t'(56);
            default: return cnt_t'(60);
        endcase
    endfunction

    function automatic cnt_t fixed_tx_level(input logic [1:0] code);
        case (code)
            2'b00:   return cnt_t'(8);
            2'b01:   return cnt_t'(16);
            2'b10:   return cnt_t'(32);
            default: return cnt_t'(56);
        endcase
    endfunction

    function automatic cnt_t sanitise_prog(input prog_t v);
        if (v == '0)
            return cnt_t'(1);
        else if (int'(v) > FIFO_DEPTH)
            return cnt_t'(FIFO_DEPTH);
        else
            return cnt_t'(v);
    endfunction

endpackage

// File: rtl/uart_trig_thr_pick.sv
module uart_trig_thr_pick
    import uart_trig_pkg::*;
(
    input  logic      fifo_en,
    input  logic [1:0] tbl_sel,
    input  logic [1:0] rx_code,
    input  logic [1:0] tx_code,
    input  prog_t     rx_prog,
    input  prog_t     tx_prog,
    output thr_pair_t thr_o
);

    thr_src_e src;

    always_comb begin
        src = decode_src(fifo_en, tbl_sel);
        unique case (src)
            SRC_FIXED: begin
                thr_o.rx = fixed_rx_level(rx_code);
                thr_o.tx = fixed_tx_level(tx_code);
            end
            SRC_PROG: begin
                thr_o.rx = sanitise_prog(rx_prog);
                thr_o.tx = sanitise_prog(tx_prog);
            end
            default: begin
                thr_o.rx = cnt_t'(1);
                thr_o.tx = '0;
            end
        endcase
    end

endmodule

// File: rtl/uart_trig_cmp.sv
module uart_trig_cmp #(
    parameter int  CNT_W  = 7,
    parameter bit  UPWARD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr,
    output logic             req
);

    logic hit;

    generate
        if (UPWARD) begin : g_fill
            assign hit = (cnt >= thr);
        end else begin : g_drain
            assign hit = (cnt <= thr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= hit;
    end

endmodule

// File: rtl/uart_trig_sel.sv
module uart_trig_sel
    import uart_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic [1:0] tbl_sel,
    input  logic [1:0] rx_code,
    input  logic [1:0] tx_code,
    input  logic [7:0] rx_prog,
    input  logic [7:0] tx_prog,
    input  logic [6:0] rx_cnt,
    input  logic [6:0] tx_cnt,
    output logic       rx_req,
    output logic       tx_req,
    output logic [6:0] rx_thr,
    output logic [6:0] tx_thr
);

    thr_pair_t thr_next;
    thr_pair_t thr_q;

    uart_trig_thr_pick u_pick (
        .fifo_en (fifo_en),
        .tbl_sel (tbl_sel),
        .rx_code (rx_code),
        .tx_code (tx_code),
        .rx_prog (rx_prog),
        .tx_prog (tx_prog),
        .thr_o   (thr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q.rx <= cnt_t'(1);
            thr_q.tx <= '0;
        end else begin
            thr_q <= thr_next;
        end
    end

    assign rx_thr = thr_q.rx;
    assign tx_thr = thr_q.tx;

    uart_trig_cmp #(.CNT_W(CNT_W), .UPWARD(1'b1)) u_rx_cmp (
        .clk (clk),
        .rst (rst),
        .cnt (rx_cnt),
        .thr (thr_next.rx),
        .req (rx_req)
    );

    uart_trig_cmp #(.CNT_W(CNT_W), .UPWARD(1'b0)) u_tx_cmp (
        .clk (clk),
        .rst (rst),
        .cnt (tx_cnt),
        .thr (thr_next.tx),
        .req (tx_req)
    );

    // R6
    rx_req_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rx_req == ($past(rx_cnt) >= rx_thr)));

    // R7
    tx_req_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tx_req == ($past(tx_cnt) <= tx_thr)));

    // R8
    single_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !tbl_sel[1]) |=> (rx_thr == 7'd1 && tx_thr == 7'd0));

    // R9
    fifo_off_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (rx_thr == 7'd1 && tx_thr == 7'd0));

    // R5
    prog_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tbl_sel == 2'b11 && rx_prog == 8'd0) |=> (rx_thr == 7'd1));

    // R5
    prog_high_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tbl_sel == 2'b11 && tx_prog > 8'd64) |=> (tx_thr == 7'd64));

    // R4
    prog_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tbl_sel == 2'b11 && rx_prog != 8'd0 && rx_prog <= 8'd64)
        |=> (rx_thr == $past(rx_prog[6:0])));

    // R2
    fixed_rx_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tbl_sel == 2'b10) |=> (rx_thr >= 7'd8 && rx_thr <= 7'd60));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rx_req && !tx_req && rx_thr == 7'd1 && tx_thr == 7'd0));

endmodule

// File: tb/uart_trig_sel_tb_top.sv
module uart_trig_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic [1:0] tbl_sel = '0;
    logic [1:0] rx_code = '0;
    logic [1:0] tx_code = '0;
    logic [7:0] rx_prog = '0;
    logic [7:0] tx_prog = '0;
    logic [6:0] rx_cnt = '0;
    logic [6:0] tx_cnt = '0;
    logic       rx_req, tx_req;
    logic [6:0] rx_thr, tx_thr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_trig_sel dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .tbl_sel(tbl_sel),
        .rx_code(rx_code), .tx_code(tx_code), .rx_prog(rx_prog), .tx_prog(tx_prog),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_req(rx_req), .tx_req(tx_req),
        .rx_thr(rx_thr), .tx_thr(tx_thr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (en=%0d sel=%0d rc=%0d tc=%0d rp=%0d tp=%0d)",
                     tag, act, exp, fifo_en, tbl_sel, rx_code, tx_code, rx_prog, tx_prog);
        end
    endtask

    function automatic int clampv(input int v);
        if (v == 0) return 1;
        if (v > 64) return 64;
        return v;
    endfunction

    function automatic int prog_val(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 5;
            3: return 63;
            4: return 64;
            5: return 65;
            default: return 200;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int erx, etx;
        string trx, ttx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_req", rx_req, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 rx_thr", rx_thr, 1);
        chk("R1 tx_thr", tx_thr, 0);
        rst = 1'b0;

        for (int en = 0; en < 2; en++)
        for (int sel = 0; sel < 4; sel++)
        for (int rc = 0; rc < 4; rc++)
        for (int tc = 0; tc < 4; tc++)
        for (int p = 0; p < 7; p++) begin
            fifo_en = en[0];
            tbl_sel = sel[1:0];
            rx_code = rc[1:0];
            tx_code = tc[1:0];
            rx_prog = 8'(prog_val(p));
            tx_prog = 8'(prog_val((p + 3) % 7));
            if (en == 0) begin
                erx = 1; etx = 0; trx = "R9 rx_thr"; ttx = "R9 tx_thr";
            end else if (sel < 2) begin
                erx = 1; etx = 0; trx = "R8 rx_thr"; ttx = "R8 tx_thr";
            end else if (sel == 2) begin
                erx = (rc == 0) ? 8 : (rc == 1) ? 16 : (rc == 2) ? 56 : 60;
                etx = (tc == 0) ? 8 : (tc == 1) ? 16 : (tc == 2) ? 32 : 56;
                trx = "R2 rx_thr"; ttx = "R3 tx_thr";
            end else begin
                erx = clampv(int'(rx_prog));
                etx = clampv(int'(tx_prog));
                trx = (rx_prog == 0 || rx_prog > 64) ? "R5 rx_thr" : "R4 rx_thr";
                ttx = (tx_prog == 0 || tx_prog > 64) ? "R5 tx_thr" : "R4 tx_thr";
            end
            for (int c = 0; c <= 64; c++) begin
                rx_cnt = 7'(c);
                tx_cnt = 7'((c * 37) % 65);
                @(posedge clk);
                @(negedge clk);
                // R10 one-cycle latency: sampled after the edge that captured inputs
                chk(trx, rx_thr, erx);
                chk(ttx, tx_thr, etx);
                chk("R6 rx_req", rx_req, (c >= erx) ? 1 : 0);
                chk("R7 tx_req", tx_req, (((c * 37) % 65) <= etx) ? 1 : 0);
            end
        end

        // R1 reset again mid-run, with a full receive FIFO
        fifo_en = 1'b1; tbl_sel = 2'b10; rx_cnt = 7'd64; tx_cnt = 7'd0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 rx_thr", rx_thr, 1);
        chk("R1 tx_thr", tx_thr, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 rx_req", rx_req, 1);
        chk("R10 tx_req", tx_req, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule